// File: doc/BRIEF.md
# Counter-Based All-Digital Phase-Locked Loop

This block recovers a clock that follows a one-bit reference input. It uses only counters and gates, and it runs on one fast system clock. Two clock-enable inputs set its timing. The step enable for the loop filter sets the filter rate, which is M times the centre frequency f0. The slot enable for the pulse-shaping stage sets the slot rate, which is 2N·f0.

The block is a chain of four stages:

1. A phase detector compares the reference with the recovered clock. It has two modes: an exclusive-OR and an edge-set/edge-clear flip-flop.
2. The detector output sets the direction of a programmable-modulus up/down counter, which acts as the loop filter.
3. When that counter overflows it emits a carry pulse, and when it underflows it emits a borrow pulse. A slot counter turns these pulses into one extra or one missing output step.
4. A divide-by-N stage turns the step stream into the recovered clock.

The loop closes because the recovered clock feeds back into the detector.

To use the block, tie the reference to `ref_in`. Pick the filter modulus with `k_mod` and the divide ratio with `n_div`. Run the slot enable at 2N times the wanted frequency. The filter size sets how many detector cycles it takes to make one correction, so it trades lock range against jitter.

Top module: `adpll_core`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `rec_clk`, `carry` and `borrow` are all 0 and every counter and pending flag is clear. This holds even when both enables are high during reset.
- R2: With `pd_sel`=0 (exclusive-OR mode), `pd_out` equals `ref_in` XOR `rec_clk` in the same cycle, with no register on the path.
- R3: With `pd_sel`=1 (flip-flop mode), a rising edge of `ref_in` sets `pd_out` at the next clock, and a rising edge of `rec_clk` clears it. If neither edge occurs, `pd_out` holds its level. Falling edges have no effect.
- R4: On each cycle with `k_en` high, the filter counter counts up when `pd_out` is 0 and down when it is 1. The modulus is 2^k, where k is `k_mod` limited to the range 3 to 16: a value below 3 acts as 3, and a value above 16 acts as 16.
- R5: An up step taken at the top value 2^k−1 reloads the counter to 0. It also raises `carry` for exactly one cycle, in the cycle after that step's edge.
- R6: A down step taken at 0 reloads the counter to 2^k−1. It also raises `borrow` for exactly one cycle, in the cycle after that step's edge.
- R7: With no corrections pending, the `id_en` cycles alternate between an even slot and an odd slot, starting with even after reset. Every odd slot advances the divider by one. The divider runs from 0 to N−1, where N is `n_div` with values below 2 treated as 2. `rec_clk` is high while the divider holds a value of at least floor(N/2). With `id_en` held high, this gives a `rec_clk` period of 2N clocks.
- R8: A carry makes the next even slot advance the divider as well, so one step is inserted.
- R9: A borrow makes the next odd slot skip its advance, so one step is deleted.
- R10: Each correction direction keeps at most one pending flag. A second carry that arrives while one is still pending has no further effect. A carry pending together with a borrow cancels both.
- R11: With the loop closed (k=3, N=16, both enables high) and the reference period 31 clocks instead of 32, the loop locks. After settling, `rec_clk` and `ref_in` show rising-edge counts within one of each other over each 3100-clock window. The time `pd_out` spends high differs by at most 10% between two consecutive windows.
- R12: `carry` and `borrow` are never high together, and each follows a cycle with `k_en` high. `rec_clk` changes only after a cycle with `id_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| k_en | input | 1 | Step enable for the filter counter (rate M·f0) |
| id_en | input | 1 | Slot enable for the step generator (rate 2N·f0) |
| pd_sel | input | 1 | Detector mode: 0 exclusive-OR, 1 edge flip-flop |
| ref_in | input | 1 | Reference bit to track |
| k_mod | input | 5 | Filter modulus exponent k |
| n_div | input | 8 | Divide ratio N |
| rec_clk | output | 1 | Recovered clock |
| pd_out | output | 1 | Phase detector output |
| carry | output | 1 | One-cycle filter overflow pulse |
| borrow | output | 1 | One-cycle filter underflow pulse |

## Verification
The results fall due at different times:

- In exclusive-OR mode, `pd_out` is combinational, so it is sampled shortly after the bench changes `ref_in`.
- `carry` and `borrow` are registered, so they are due in the cycle that follows the rising edge on which the enabling `k_en` step was taken.
- `rec_clk` moves on the same edge as the `id_en` slot that advances the divider.
- In flip-flop mode, `pd_out` follows one edge after the edge that registers the rising input.

The bench drives every input and reads every output at the falling clock edge. Each step task therefore returns with exactly one rising edge applied, and its result is due at that point. The step and slot counts needed for the corrections follow directly from the reload values and slot parity stated above.

// File: rtl/adpll_pkg.sv
package adpll_pkg;

    typedef enum logic {
        PD_XOR = 1'b0,
        PD_JK  = 1'b1
    } pd_mode_e;

    typedef struct packed {
        logic jk;
        logic ref_prev;
        logic fb_prev;
    } pd_state_t;

    typedef struct packed {
        logic ph;
        logic inc_pend;
        logic dec_pend;
    } slot_state_t;

    localparam int KMOD_MIN = 3;

endpackage

// File: rtl/adpll_phdet.sv
module adpll_phdet
    import adpll_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pd_mode_e mode,
    input  logic     ref_in,
    input  logic     fb,
    output logic     pd
);
    pd_state_t st_d, st_q;
    logic ref_rise, fb_rise;

    always_comb begin
        st_d     = st_q;
        ref_rise = ref_in & ~st_q.ref_prev;
        fb_rise  = fb & ~st_q.fb_prev;
        st_d.ref_prev = ref_in;
        st_d.fb_prev  = fb;
        case ({ref_rise, fb_rise})
            2'b10:   st_d.jk = 1'b1;
            2'b01:   st_d.jk = 1'b0;
            2'b11:   st_d.jk = ~st_q.jk;
            default: st_d.jk = st_q.jk;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pd = (mode == PD_JK) ? st_q.jk : (ref_in ^ fb);

endmodule

// File: rtl/adpll_kfilter.sv
module adpll_kfilter
    import adpll_pkg::*;
#(
    parameter int KW  = 16,
    parameter int KSW = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           k_en,
    input  logic           dn,
    input  logic [KSW-1:0] k_mod,
    output logic           carry,
    output logic           borrow
);
    typedef struct packed {
        logic [KW-1:0] cnt;
        logic          cy;
        logic          bw;
    } kf_state_t;

    kf_state_t      st_d, st_q;
    logic [KSW-1:0] k_eff;
    logic [KW:0]    lim_wide;
    logic [KW-1:0]  lim;

    always_comb begin
        if (k_mod < KSW'(KMOD_MIN))      k_eff = KSW'(KMOD_MIN);
        else if (k_mod > KSW'(KW))       k_eff = KSW'(KW);
        else                             k_eff = k_mod;
        lim_wide = ((KW+1)'(1) << k_eff) - (KW+1)'(1);
        lim      = lim_wide[KW-1:0];
    end

    always_comb begin
        st_d    = st_q;
        st_d.cy = 1'b0;
        st_d.bw = 1'b0;
        if (k_en) begin
            if (dn) begin
                if (st_q.cnt == '0) begin
                    st_d.cnt = lim;
                    st_d.bw  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - KW'(1);
                end
            end else begin
                if (st_q.cnt >= lim) begin
                    st_d.cnt = '0;
                    st_d.cy  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + KW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign carry  = st_q.cy;
    assign borrow = st_q.bw;

endmodule

// File: rtl/adpll_slotter.sv
module adpll_slotter
    import adpll_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic id_en,
    input  logic carry,
    input  logic borrow,
    output logic step
);
    slot_state_t st_d, st_q;
    logic inc_keep, dec_keep, inc_n, dec_n;

    always_comb begin
        st_d     = st_q;
        step     = 1'b0;
        inc_keep = st_q.inc_pend;
        dec_keep = st_q.dec_pend;
        if (id_en) begin
            st_d.ph = ~st_q.ph;
            if (!st_q.ph) begin
                // even slot: used only to insert a step
                step     = st_q.inc_pend;
                inc_keep = 1'b0;
            end else begin
                // odd slot: normal step unless a deletion is pending
                step     = ~st_q.dec_pend;
                dec_keep = 1'b0;
            end
        end
        inc_n = inc_keep | carry;
        dec_n = dec_keep | borrow;
        if (inc_n && dec_n) begin
            inc_n = 1'b0;
            dec_n = 1'b0;
        end
        st_d.inc_pend = inc_n;
        st_d.dec_pend = dec_n;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/adpll_divn.sv
module adpll_divn #(
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic [NW-1:0] n_div,
    output logic          rec
);
    typedef struct packed {
        logic [NW-1:0] cnt;
        logic          rec;
    } dv_state_t;

    dv_state_t     st_d, st_q;
    logic [NW-1:0] n_eff, half, cnt_n;

    always_comb begin
        n_eff = (n_div < NW'(2)) ? NW'(2) : n_div;
        half  = n_eff >> 1;
        st_d  = st_q;
        cnt_n = st_q.cnt;
        if (step) begin
            if (st_q.cnt >= n_eff - NW'(1)) cnt_n = '0;
            else                            cnt_n = st_q.cnt + NW'(1);
            st_d.cnt = cnt_n;
            st_d.rec = (cnt_n >= half);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rec = st_q.rec;

endmodule

// File: rtl/adpll_core.sv
module adpll_core
    import adpll_pkg::*;
#(
    parameter int KW  = 16,
    parameter int KSW = 5,
    parameter int NW  = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           k_en,
    input  logic           id_en,
    input  logic           pd_sel,
    input  logic           ref_in,
    input  logic [KSW-1:0] k_mod,
    input  logic [NW-1:0]  n_div,
    output logic           rec_clk,
    output logic           pd_out,
    output logic           carry,
    output logic           borrow
);
    logic step;

    adpll_phdet u_pd (
        .clk    (clk),
        .rst    (rst),
        .mode   (pd_mode_e'(pd_sel)),
        .ref_in (ref_in),
        .fb     (rec_clk),
        .pd     (pd_out)
    );

    adpll_kfilter #(.KW(KW), .KSW(KSW)) u_kf (
        .clk    (clk),
        .rst    (rst),
        .k_en   (k_en),
        .dn     (pd_out),
        .k_mod  (k_mod),
        .carry  (carry),
        .borrow (borrow)
    );

    adpll_slotter u_slot (
        .clk    (clk),
        .rst    (rst),
        .id_en  (id_en),
        .carry  (carry),
        .borrow (borrow),
        .step   (step)
    );

    adpll_divn #(.NW(NW)) u_div (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .n_div (n_div),
        .rec   (rec_clk)
    );

endmodule

// File: rtl/adpll_core_chk.sv
module adpll_core_chk (
    input logic clk,
    input logic rst,
    input logic k_en,
    input logic id_en,
    input logic carry,
    input logic borrow,
    input logic rec_clk
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rec_clk && !carry && !borrow));

    assert_carry_single_R5: assert property (@(posedge clk) disable iff (rst)
        carry |=> !carry);

    assert_borrow_single_R6: assert property (@(posedge clk) disable iff (rst)
        borrow |=> !borrow);

    assert_corr_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        !(carry && borrow));

    assert_carry_after_step_R12: assert property (@(posedge clk) disable iff (rst)
        carry |-> $past(k_en));

    assert_borrow_after_step_R12: assert property (@(posedge clk) disable iff (rst)
        borrow |-> $past(k_en));

    assert_rec_on_slot_R12: assert property (@(posedge clk) disable iff (rst)
        !$stable(rec_clk) |-> $past(id_en));

endmodule

bind adpll_core adpll_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .k_en    (k_en),
    .id_en   (id_en),
    .carry   (carry),
    .borrow  (borrow),
    .rec_clk (rec_clk)
);

// File: tb/adpll_core_test.sv
module adpll_core_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       k_en = 1'b0, id_en = 1'b0, pd_sel = 1'b0, ref_in = 1'b0;
    logic [4:0] k_mod = 5'd3;
    logic [7:0] n_div = 8'd2;
    logic       rec_clk, pd_out, carry, borrow;

    int n_chk = 0;
    int n_bad = 0;

    // nominal-period vectors: divide ratio and expected rec_clk period (R7)
    localparam int NVEC = 6;
    localparam int TBL_N[NVEC] = '{0, 1, 2, 3, 5, 8};
    localparam int TBL_P[NVEC] = '{4, 4, 4, 6, 10, 16};

    always #2 clk = ~clk;

    adpll_core uut (
        .clk(clk), .rst(rst), .k_en(k_en), .id_en(id_en), .pd_sel(pd_sel),
        .ref_in(ref_in), .k_mod(k_mod), .n_div(n_div),
        .rec_clk(rec_clk), .pd_out(pd_out), .carry(carry), .borrow(borrow)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply_reset(input logic mode);
        @(negedge clk);
        rst = 1'b1; k_en = 1'b0; id_en = 1'b0; ref_in = 1'b0; pd_sel = mode;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic kstep(input int n);
        repeat (n) begin
            k_en = 1'b1;
            @(negedge clk);
            k_en = 1'b0;
        end
    endtask

    task automatic idstep(input int n);
        repeat (n) begin
            id_en = 1'b1;
            @(negedge clk);
            id_en = 1'b0;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset holds outputs low even with enables active
        @(negedge clk);
        rst = 1'b1; k_en = 1'b1; id_en = 1'b1; ref_in = 1'b0;
        repeat (4) @(negedge clk);
        check_eq("R1 rec_clk in reset", int'(rec_clk), 0);
        check_eq("R1 carry in reset", int'(carry), 0);
        apply_reset(1'b0);
        check_eq("R1 rec_clk after reset", int'(rec_clk), 0);
        check_eq("R1 borrow after reset", int'(borrow), 0);

        // R2: exclusive-OR detector
        ref_in = 1'b1; #1;
        check_eq("R2 pd ref=1 rec=0", int'(pd_out), 1);
        idstep(2);
        check_eq("R7 rec high after two slots N=2", int'(rec_clk), 1);
        #1;
        check_eq("R2 pd ref=1 rec=1", int'(pd_out), 0);
        ref_in = 1'b0; #1;
        check_eq("R2 pd ref=0 rec=1", int'(pd_out), 1);

        // R7: table of nominal periods
        for (int v = 0; v < NVEC; v++) begin
            int t, r, p0, per;
            logic prev;
            apply_reset(1'b0);
            n_div = 8'(TBL_N[v]);
            id_en = 1'b1;
            t = 0; r = 0; p0 = 0; per = -1; prev = rec_clk;
            for (int c = 0; c < 200; c++) begin
                @(negedge clk);
                t++;
                if (rec_clk && !prev) begin
                    r++;
                    if (r == 1) p0 = t;
                    else begin
                        per = t - p0;
                        break;
                    end
                end
                prev = rec_clk;
            end
            id_en = 1'b0;
            check_eq("R7 nominal period", per, TBL_P[v]);
        end

        // R5: carry at the top value, one cycle, reload to zero
        apply_reset(1'b0);
        k_mod = 5'd3;
        kstep(7);
        check_eq("R5 no carry before top", int'(carry), 0);
        kstep(1);
        check_eq("R5 carry on overflow", int'(carry), 1);
        @(negedge clk);
        check_eq("R5 carry lasts one cycle", int'(carry), 0);
        kstep(7);
        check_eq("R5 reload zero, no early carry", int'(carry), 0);
        kstep(1);
        check_eq("R5 second carry", int'(carry), 1);

        // R6: borrow from zero, reload to top
        apply_reset(1'b0);
        ref_in = 1'b1;
        kstep(1);
        check_eq("R6 borrow from zero", int'(borrow), 1);
        @(negedge clk);
        check_eq("R6 borrow lasts one cycle", int'(borrow), 0);
        kstep(7);
        check_eq("R6 reload top, no early borrow", int'(borrow), 0);
        kstep(1);
        check_eq("R6 second borrow", int'(borrow), 1);

        // R4: modulus selection and clamping
        apply_reset(1'b0);
        k_mod = 5'd4;
        kstep(15);
        check_eq("R4 k=4 no carry at 15", int'(carry), 0);
        kstep(1);
        check_eq("R4 k=4 carry at 16", int'(carry), 1);
        apply_reset(1'b0);
        k_mod = 5'd1;
        kstep(8);
        check_eq("R4 k=1 acts as 3", int'(carry), 1);
        k_mod = 5'd3;

        // R8: carry inserts a step on the even slot
        apply_reset(1'b0);
        n_div = 8'd2;
        kstep(8);
        repeat (2) @(negedge clk);
        idstep(1);
        check_eq("R8 inserted step raises rec", int'(rec_clk), 1);

        // R9: borrow deletes the next odd-slot step
        apply_reset(1'b0);
        ref_in = 1'b1;
        kstep(1);
        ref_in = 1'b0;
        repeat (2) @(negedge clk);
        idstep(3);
        check_eq("R9 deleted step keeps rec low", int'(rec_clk), 0);
        idstep(1);
        check_eq("R9 next odd slot steps", int'(rec_clk), 1);

        // R10: one-deep pending flag
        apply_reset(1'b0);
        kstep(16);
        repeat (2) @(negedge clk);
        idstep(1);
        check_eq("R10 first carry applied", int'(rec_clk), 1);
        idstep(2);
        check_eq("R10 second carry not held", int'(rec_clk), 0);
        idstep(1);
        check_eq("R10 normal step after", int'(rec_clk), 1);

        // R10: carry and borrow pending together cancel
        apply_reset(1'b0);
        kstep(8);
        ref_in = 1'b1;
        kstep(1);
        ref_in = 1'b0;
        repeat (2) @(negedge clk);
        idstep(1);
        check_eq("R10 cancel: no insert", int'(rec_clk), 0);
        idstep(1);
        check_eq("R10 cancel: no delete", int'(rec_clk), 1);

        // R3: edge flip-flop detector
        apply_reset(1'b1);
        n_div = 8'd2;
        check_eq("R3 cleared after reset", int'(pd_out), 0);
        ref_in = 1'b1;
        @(negedge clk);
        check_eq("R3 set by ref rise", int'(pd_out), 1);
        ref_in = 1'b0;
        repeat (2) @(negedge clk);
        check_eq("R3 ref fall has no effect", int'(pd_out), 1);
        idstep(2);
        @(negedge clk);
        check_eq("R3 cleared by rec rise", int'(pd_out), 0);

        // R11: closed-loop lock to a reference one clock shorter per period
        begin
            int rc, ref_r[2], rec_r[2], hi[2], w;
            logic prev_rec;
            apply_reset(1'b0);
            n_div = 8'd16; k_mod = 5'd3;
            k_en = 1'b1; id_en = 1'b1;
            rc = 0; prev_rec = 1'b0;
            ref_r = '{0, 0}; rec_r = '{0, 0}; hi = '{0, 0};
            for (int c = 0; c < 9200; c++) begin
                @(negedge clk);
                w = (c < 3000) ? -1 : ((c < 6100) ? 0 : 1);
                if (w >= 0) begin
                    if (rec_clk && !prev_rec) rec_r[w]++;
                    if (pd_out) hi[w]++;
                end
                prev_rec = rec_clk;
                rc = (rc == 30) ? 0 : rc + 1;
                if (rc == 0 && w >= 0) ref_r[w]++;
                ref_in = (rc < 15) ? 1'b1 : 1'b0;
            end
            k_en = 1'b0; id_en = 1'b0;
            for (int i = 0; i < 2; i++) begin
                int d;
                d = ref_r[i] - rec_r[i];
                if (d < 0) d = -d;
                check_eq("R11 edge counts within one", int'(d <= 1), 1);
            end
            begin
                int dd;
                dd = hi[0] - hi[1];
                if (dd < 0) dd = -dd;
                check_eq("R11 detector duty settled", int'(dd <= 310), 1);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule